// File: doc/BRIEF.md
# Semaphore Fence Release Unit

This block listens to the method-write stream of a 3D engine and owns a window of four consecutive method slots: the upper and lower halves of a 64-bit fence address, a 32-bit payload, and a control word. Software normally loads all four in one incrementing burst. The payload is a sequence number that goes up by one for each command list.

Writing the control slot is the trigger. If the operation field of the control word selects release, the unit writes the stored payload as one 32-bit word to the stored 64-bit address. It does this over a request/acknowledge write port. Software then polls that location and treats earlier work as complete once the value read back is greater than or equal to the last sequence number it issued. To keep ordering, the unit holds the method bus off while a release waits for its acknowledge. The other operation codes are accepted but cause no memory write, and they raise a one-cycle unsupported-operation flag.

Top module: `sem_release_unit`

## Requirements
- R1: After reset, `wr_req` is 0, `unsup_op` is 0 and `mth_ready` is 1.
- R2: An accepted write to the address-high, address-low or payload slot never starts a memory write.
- R3: Slot numbers are `BASE_IDX`+0 for the upper address half, +1 for the lower half, +2 for the payload and +3 for control. An accepted control write whose bits [1:0] equal 0 (release) raises `wr_req` in the next cycle. At that point `wr_addr` = {upper half, lower half} and `wr_data` = payload, both taken as stored before the control write.
- R4: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` hold their values.
- R5: `mth_ready` is 0 for as long as a release is pending. `wr_req` falls and `mth_ready` rises in the cycle after the edge that samples `wr_ack` high.
- R6: An accepted control write with bits [1:0] equal to 1, 2 or 3 starts no memory write and pulses `unsup_op` high for exactly the following cycle.
- R7: Control bits other than [1:0] (including the fence bit 4, the unit field [15:12] and the one-word bit 28) do not change the address or data of the release.
- R8: Accepted methods whose slot number is outside `BASE_IDX`..`BASE_IDX`+3 change no stored value and start no write.
- R9: Stored address and payload persist across releases. A later control write reuses any slot that was not rewritten.
- R10: The four slots can be written on consecutive cycles, with the control write accepted right after the payload write. The release then carries the payload from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mth_valid | input | 1 | Method write present |
| mth_ready | output | 1 | Unit can take a method this cycle |
| mth_idx | input | IDX_W | Method slot number (word granular) |
| mth_data | input | DATA_W | Method argument |
| wr_req | output | 1 | Memory write request |
| wr_ack | input | 1 | Memory write accepted |
| wr_addr | output | 2*DATA_W | Byte address of the fence word |
| wr_data | output | DATA_W | Word written to memory |
| unsup_op | output | 1 | One-cycle flag for a non-release control write |

## Verification
A release request is due in the cycle right after the clock edge that accepts the control write. The flag for an unsupported control write is due in that same cycle. The bench drives each method at a falling edge, waits for `mth_ready`, and then checks `wr_req` and `unsup_op` at the first falling edge after the accepting rising edge. The acknowledge responder raises `wr_ack` after a chosen number of falling edges, comparing the request against the scoreboard queue and checking that the bus is stalled while it waits. At the falling edge after the acknowledge, it confirms that `wr_req` has dropped and `mth_ready` has returned.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int OP_LSB    = 0;
    localparam int OP_W      = 2;

    typedef enum logic [1:0] {
        SLOT_ADDR_HI = 2'd0,
        SLOT_ADDR_LO = 2'd1,
        SLOT_PAYLOAD = 2'd2,
        SLOT_CTRL    = 2'd3
    } slot_e;

    typedef enum logic [OP_W-1:0] {
        OP_RELEASE = 2'd0,
        OP_RSVD1   = 2'd1,
        OP_RSVD2   = 2'd2,
        OP_RSVD3   = 2'd3
    } op_e;

endpackage

// File: rtl/sem_decode.sv
module sem_decode
    import sem_pkg::*;
#(
    parameter int          IDX_W    = 12,
    parameter logic [11:0] BASE_IDX = 12'h6C0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_SLOTS-1:0] sel
);

    localparam logic [IDX_W-1:0] BASE = IDX_W'(BASE_IDX);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign sel[s] = accept && (idx == BASE + IDX_W'(s));
    end

    // At most one slot is hit by any accepted method (R8 window decode)
    a_r8_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/sem_regs.sv
module sem_regs #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_hi,
    input  logic                  we_lo,
    input  logic                  we_pay,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   fence_addr,
    output logic [DATA_W-1:0]     payload
);

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] pay;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_hi)  st_d.hi  = wdata;
        if (we_lo)  st_d.lo  = wdata;
        if (we_pay) st_d.pay = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fence_addr = {st_q.hi, st_q.lo};
    assign payload    = st_q.pay;

    // R9: stored values persist when their slot is not written
    a_r9_keep_pay: assert property (@(posedge clk) disable iff (!rst_n)
        !we_pay |=> $stable(payload));
    a_r9_keep_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_hi || we_lo) |=> $stable(fence_addr));

endmodule

// File: rtl/sem_issue.sv
module sem_issue
    import sem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [DATA_W-1:0]     ctrl_data,
    input  logic [2*DATA_W-1:0]   addr_in,
    input  logic [DATA_W-1:0]     pay_in,
    input  logic                  wr_ack,
    output logic                  busy,
    output logic [2*DATA_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  unsup
);

    typedef struct packed {
        logic                busy;
        logic                unsup;
        logic [2*DATA_W-1:0] addr;
        logic [DATA_W-1:0]   data;
    } iss_t;

    iss_t st_d, st_q;
    op_e  op;

    assign op = op_e'(ctrl_data[OP_LSB +: OP_W]);

    always_comb begin
        st_d       = st_q;
        st_d.unsup = 1'b0;
        if (st_q.busy && wr_ack) begin
            st_d.busy = 1'b0;
        end
        if (ctrl_we) begin
            if (op == OP_RELEASE) begin
                st_d.busy = 1'b1;
                st_d.addr = addr_in;
                st_d.data = pay_in;
            end else begin
                st_d.unsup = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;
    assign unsup   = st_q.unsup;

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && op == OP_RELEASE) |=>
            (busy && wr_data == $past(pay_in) && wr_addr == $past(addr_in)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_ack) |=> (busy && $stable(wr_addr) && $stable(wr_data)));
    a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_ack));
    a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && op != OP_RELEASE) |=> (unsup && !busy));
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_we) |=> !busy);

endmodule

// File: rtl/sem_release_unit.sv
module sem_release_unit
    import sem_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          IDX_W    = 12,
    parameter logic [11:0] BASE_IDX = 12'h6C0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mth_valid,
    output logic                  mth_ready,
    input  logic [IDX_W-1:0]      mth_idx,
    input  logic [DATA_W-1:0]     mth_data,
    output logic                  wr_req,
    input  logic                  wr_ack,
    output logic [2*DATA_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  unsup_op
);

    logic                  accept;
    logic [NUM_SLOTS-1:0]  sel;
    logic [2*DATA_W-1:0]   fence_addr;
    logic [DATA_W-1:0]     payload;
    logic                  busy;

    assign mth_ready = !busy;
    assign accept    = mth_valid && mth_ready;
    assign wr_req    = busy;

    sem_decode #(.IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .idx    (mth_idx),
        .sel    (sel)
    );

    sem_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_hi      (sel[SLOT_ADDR_HI]),
        .we_lo      (sel[SLOT_ADDR_LO]),
        .we_pay     (sel[SLOT_PAYLOAD]),
        .wdata      (mth_data),
        .fence_addr (fence_addr),
        .payload    (payload)
    );

    sem_issue #(.DATA_W(DATA_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (sel[SLOT_CTRL]),
        .ctrl_data (mth_data),
        .addr_in   (fence_addr),
        .pay_in    (payload),
        .wr_ack    (wr_ack),
        .busy      (busy),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .unsup     (unsup_op)
    );

    // R5: a pending release blocks the method bus until acknowledged
    a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> !mth_ready);
    // R6: unsupported flag and a new request never start together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> !unsup_op);

endmodule

// File: tb/sem_release_unit_tb.sv
module sem_release_unit_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 32;
    localparam int          IW         = 12;
    localparam logic [11:0] BASE       = 12'h6C0;
    localparam int          WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mth_valid = 1'b0;
    logic          mth_ready;
    logic [IW-1:0] mth_idx = '0;
    logic [DW-1:0] mth_data = '0;
    logic          wr_req;
    logic          wr_ack = 1'b0;
    logic [2*DW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          unsup_op;

    int errors = 0;
    int checks = 0;
    int ack_delay = 0;
    bit done = 1'b0;
    logic [3*DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_release_unit #(.DATA_W(DW), .IDX_W(IW), .BASE_IDX(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .mth_valid(mth_valid), .mth_ready(mth_ready),
        .mth_idx(mth_idx), .mth_data(mth_data), .wr_req(wr_req), .wr_ack(wr_ack),
        .wr_addr(wr_addr), .wr_data(wr_data), .unsup_op(unsup_op)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge; returns at the falling edge after accept
    task automatic mw(input int slot_off, input logic [DW-1:0] d);
        bit is_ctrl = (slot_off == 3);
        mth_valid = 1'b1;
        mth_idx   = IW'(BASE) + IW'(slot_off);
        mth_data  = d;
        if (is_ctrl && d[1:0] == 2'd0)
            exp_q.push_back({sh_hi, sh_lo, sh_pay});
        while (!mth_ready) @(negedge clk);
        @(negedge clk);
        mth_valid = 1'b0;
        if (slot_off == 0) sh_hi = d;
        if (slot_off == 1) sh_lo = d;
        if (slot_off == 2) sh_pay = d;
        if (is_ctrl) begin
            if (d[1:0] == 2'd0) begin
                check(wr_req == 1'b1, "R3 request next cycle", wr_req, 1);
            end else begin
                check(unsup_op == 1'b1 && wr_req == 1'b0, "R6 flag without write",
                      {unsup_op, wr_req}, 2'b10);
                @(negedge clk);
                check(unsup_op == 1'b0, "R6 one-cycle flag", unsup_op, 0);
            end
        end else begin
            check(wr_req == 1'b0 && unsup_op == 1'b0, "R2/R8 no write from data slot",
                  {wr_req, unsup_op}, 0);
        end
    endtask

    logic [DW-1:0] sh_hi = '0, sh_lo = '0, sh_pay = '0;

    // Monitor and acknowledge responder (scoreboard pop side)
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_ack) begin
                wr_ack = 1'b0;
                check(wr_req == 1'b0 && mth_ready == 1'b1, "R5 release after ack",
                      {wr_req, mth_ready}, 2'b01);
            end else if (wr_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected memory write", wr_data, 0);
                end else begin
                    check(wr_addr == exp_q[0][3*DW-1:DW] && wr_data == exp_q[0][DW-1:0],
                          "R3/R4/R7 write contents", {wr_addr, wr_data}, exp_q[0]);
                    check(mth_ready == 1'b0, "R5 stall while pending", mth_ready, 0);
                    if (wait_cnt >= ack_delay) begin
                        void'(exp_q.pop_front());
                        wait_cnt = 0;
                        wr_ack = 1'b1;
                    end else begin
                        wait_cnt++;
                    end
                end
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0 || wr_req || wr_ack) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wr_req == 0 && unsup_op == 0 && mth_ready == 1, "R1 reset state",
              {wr_req, unsup_op, mth_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 back-to-back burst, immediate ack
        ack_delay = 0;
        mw(0, 32'h0000_0001); mw(1, 32'h2000_0040); mw(2, 32'd1); mw(3, 32'h1000_F010);
        drain();

        // R9 only payload advances, slow ack exercises R4/R5
        ack_delay = 3;
        mw(2, 32'd2); mw(3, 32'h1000_F010);
        drain();

        // R6 non-release operations
        mw(3, 32'h1000_F011); mw(3, 32'h0000_0002); mw(3, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        check(wr_req == 1'b0, "R6 no write after unsupported ops", wr_req, 0);

        // R2 address-only update, then R7 control with all other bits set
        mw(0, 32'h0000_00AB);
        repeat (2) @(negedge clk);
        check(wr_req == 1'b0, "R2 address write alone is silent", wr_req, 0);
        ack_delay = 1;
        mw(2, 32'd3); mw(3, 32'hFFFF_FFFC);
        drain();

        // R8 writes just outside the window leave state untouched
        mw(-1, 32'hDEAD_BEEF); mw(4, 32'hCAFE_F00D);
        ack_delay = 0;
        mw(3, 32'h0000_0000);
        drain();

        // R10 second burst with a new address
        ack_delay = 2;
        mw(0, 32'h0000_0002); mw(1, 32'h0000_1000); mw(2, 32'd4); mw(3, 32'h1000_F010);
        drain();
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule